// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the four status flags of a serial port that runs either as an asynchronous UART or as a clocked synchronous link. The transmit and receive datapaths send it single-cycle event strobes. These are a CPU write to the send buffer, a move of that buffer into the transmit shift register, a completed reception, and the per-frame quality bits that come with a completed reception: parity mismatch, a bad start sample and a bad stop sample.

From these events the block keeps a send-buffer-full flag and three sticky error flags. A CPU read of the status word returns the flags and clears all four of them. The block also decides whether a freshly received word may enter the receive buffer. When the previous word has not yet been taken by the CPU, the new word is refused and an overrun is recorded. Every completed reception raises a one-cycle receive interrupt request, and the updated flags are visible in the same cycle as that request.

The block has no data stream of its own. Every pin is a plain control or status strobe, so no valid/ready back-pressure applies.

Top module: `sio_status_reg`

## Requirements
- R1: After reset, `stat_rdata` is 4'b0000, `rx_irq` is 0, and the receive buffer counts as empty.
- R2: Bit 3 of `stat_rdata` (send buffer full) becomes 1 in the cycle after `tx_wr_stb`. It becomes 0 in the cycle after `tx_load_stb` when no write comes in the same cycle. A write and a load in the same cycle leave it at 1.
- R3: A `tx_wr_stb` while bit 3 is already 1 leaves bit 3 at 1 and changes none of bits 2..0.
- R4: Bit 2 (parity error) becomes 1 in the cycle after a `rx_done_stb` that comes with `rx_parity_bad`, in either mode. It stays 1 until a status read.
- R5: A `rx_done_stb` while the receive buffer still holds an untaken word drives `rx_buf_load` low in that cycle. It also sets bit 1 (overrun) in the next cycle, and the flag stays set until a status read.
- R6: `rx_buf_load` is high in the same cycle as `rx_done_stb` when the receive buffer is empty, or when `rx_buf_taken_stb` is asserted in that same cycle. The taken strobe empties the buffer.
- R7: Bit 0 (framing error) becomes 1 in the cycle after a `rx_done_stb` that comes with `rx_start_bad` or `rx_stop_bad` while `uart_mode` is 1. While `uart_mode` is 0 these events are ignored and bit 0 reads 0.
- R8: In the cycle of `stat_rd_stb`, `stat_rdata` shows the current flags. In the next cycle all four flags are 0, unless a set event came in the read cycle.
- R9: A set event in the same cycle as `stat_rd_stb` takes priority: its flag reads 1 in the next cycle.
- R10: `rx_irq` is high for exactly the one cycle after each `rx_done_stb`, including frames with framing errors. The flags set by that frame are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_mode | input | 1 | 1 = UART framing, 0 = synchronous mode |
| tx_wr_stb | input | 1 | CPU wrote the send buffer |
| tx_load_stb | input | 1 | Send buffer moved into the transmit shift register |
| rx_done_stb | input | 1 | A reception finished |
| rx_parity_bad | input | 1 | Parity mismatch, qualified by `rx_done_stb` |
| rx_start_bad | input | 1 | Start sample read 1, qualified by `rx_done_stb` |
| rx_stop_bad | input | 1 | Stop sample read 0, qualified by `rx_done_stb` |
| rx_buf_taken_stb | input | 1 | CPU read the receive buffer |
| stat_rd_stb | input | 1 | CPU reads the status word (clear on read) |
| stat_rdata | output | 4 | {send full, parity err, overrun, framing err} |
| rx_buf_load | output | 1 | Receive buffer may capture the new word this cycle |
| rx_irq | output | 1 | One-cycle receive interrupt request |

## Verification
The block has no tunable parameters, so the bench builds the only configuration there is. The flag width and bit order are fixed by the package. Random strobes are issued densely, and status reads are frequent. This makes the collisions within a single cycle common in the random phase: a write with a load, a completion with a taken strobe, and a set event with a read-clear. Mode flips then make framing events fall on both sides of the UART qualifier.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
  localparam int FLAG_W    = 4;
  localparam int ERR_N     = 3;
  localparam int BIT_BFULL = 3;
  localparam int BIT_PERR  = 2;
  localparam int BIT_OERR  = 1;
  localparam int BIT_FERR  = 0;
  localparam int ERR_BASE  = BIT_FERR;
endpackage

// File: rtl/sio_txbuf_track.sv
module sio_txbuf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic load_stb,
  input  logic clr_stb,
  output logic full
);
  // A fresh write wins over both the transfer and the read-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= wr_stb | (full & ~load_stb & ~clr_stb);
  end
endmodule

// File: rtl/sio_rxbuf_gate.sv
module sio_rxbuf_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic done_stb,
  input  logic taken_stb,
  output logic load_en,
  output logic overrun_ev
);
  logic occupied_q;

  // A take in the same cycle frees the slot in time for the new word.
  always_comb begin
    load_en    = done_stb & (~occupied_q | taken_stb);
    overrun_ev = done_stb & occupied_q & ~taken_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occupied_q <= 1'b0;
    else        occupied_q <= load_en | (occupied_q & ~taken_stb);
  end
endmodule

// File: rtl/sio_err_flag.sv
module sio_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_stb,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_ev | (flag & ~clr_stb);
  end
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_mode,
  input  logic              tx_wr_stb,
  input  logic              tx_load_stb,
  input  logic              rx_done_stb,
  input  logic              rx_parity_bad,
  input  logic              rx_start_bad,
  input  logic              rx_stop_bad,
  input  logic              rx_buf_taken_stb,
  input  logic              stat_rd_stb,
  output logic [FLAG_W-1:0] stat_rdata,
  output logic              rx_buf_load,
  output logic              rx_irq
);
  logic             bfull_q;
  logic             overrun_ev;
  logic [ERR_N-1:0] err_set;
  logic [ERR_N-1:0] err_q;

  sio_txbuf_track u_txbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (tx_wr_stb),
    .load_stb (tx_load_stb),
    .clr_stb  (stat_rd_stb),
    .full     (bfull_q)
  );

  sio_rxbuf_gate u_rxgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_stb   (rx_done_stb),
    .taken_stb  (rx_buf_taken_stb),
    .load_en    (rx_buf_load),
    .overrun_ev (overrun_ev)
  );

  always_comb begin
    err_set                      = '0;
    err_set[BIT_PERR - ERR_BASE] = rx_done_stb & rx_parity_bad;
    err_set[BIT_OERR - ERR_BASE] = overrun_ev;
    err_set[BIT_FERR - ERR_BASE] = rx_done_stb & uart_mode & (rx_start_bad | rx_stop_bad);
  end

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    sio_err_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (err_set[g]),
      .clr_stb (stat_rd_stb),
      .flag    (err_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= rx_done_stb;
  end

  always_comb begin
    stat_rdata            = '0;
    stat_rdata[BIT_BFULL] = bfull_q;
    stat_rdata[BIT_PERR]  = err_q[BIT_PERR - ERR_BASE];
    stat_rdata[BIT_OERR]  = err_q[BIT_OERR - ERR_BASE];
    stat_rdata[BIT_FERR]  = err_q[BIT_FERR - ERR_BASE] & uart_mode;
  end
endmodule

// File: rtl/sio_status_reg_chk.sv
module sio_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uart_mode,
  input logic       tx_wr_stb,
  input logic       tx_load_stb,
  input logic       rx_done_stb,
  input logic       rx_parity_bad,
  input logic       rx_start_bad,
  input logic       rx_stop_bad,
  input logic       rx_buf_taken_stb,
  input logic       stat_rd_stb,
  input logic [3:0] stat_rdata,
  input logic       rx_buf_load,
  input logic       rx_irq
);
  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_stb |=> stat_rdata[3]); // R2
  AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_stb && rx_parity_bad) |=> stat_rdata[2]); // R4
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[2] && !stat_rd_stb) |=> stat_rdata[2]); // R4
  AST_BLOCKED_IS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_stb && !rx_buf_load) |=> stat_rdata[1]); // R5
  AST_LOAD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_load |-> rx_done_stb); // R6
  AST_SYNC_NO_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_mode |-> !stat_rdata[0]); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_stb && !tx_wr_stb && !rx_done_stb) |=> (stat_rdata == 4'b0000)); // R8
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_stb |=> rx_irq); // R10
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done_stb |=> !rx_irq); // R10
endmodule

bind sio_status_reg sio_status_reg_chk chk_i (.*);

// File: tb/sio_status_reg_tb.sv
module sio_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_mode = 1'b1;
  logic tx_wr_stb = 1'b0, tx_load_stb = 1'b0, rx_done_stb = 1'b0;
  logic rx_parity_bad = 1'b0, rx_start_bad = 1'b0, rx_stop_bad = 1'b0;
  logic rx_buf_taken_stb = 1'b0, stat_rd_stb = 1'b0;
  logic [3:0] stat_rdata;
  logic rx_buf_load, rx_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // bench model state
  logic m_bfull = 0, m_perr = 0, m_oerr = 0, m_ferr = 0, m_rxfull = 0, m_irq = 0;

  always #10 clk = ~clk;

  sio_status_reg dut_i (.*);

  function automatic logic [3:0] exp_stat();
    return {m_bfull, m_perr, m_oerr, m_ferr & uart_mode};
  endfunction

  function automatic logic exp_load();
    return rx_done_stb & (~m_rxfull | rx_buf_taken_stb);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a negedge: checks state from the last edge, applies inputs,
  // checks the combinational gate, advances the model, returns at next negedge.
  task automatic cycle(string tag, logic md, logic wr, logic ld, logic dn, logic pb,
                       logic sb, logic pbs, logic tk, logic rd);
    logic el;
    chk({tag, " status (R2/R4/R5/R7)"}, stat_rdata, exp_stat());
    chk({tag, " irq (R10)"}, {3'b0, rx_irq}, {3'b0, m_irq});
    uart_mode = md; tx_wr_stb = wr; tx_load_stb = ld; rx_done_stb = dn;
    rx_parity_bad = pb; rx_start_bad = sb; rx_stop_bad = pbs;
    rx_buf_taken_stb = tk; stat_rd_stb = rd;
    #1;
    el = exp_load();
    chk({tag, " rx load gate (R5/R6)"}, {3'b0, rx_buf_load}, {3'b0, el});
    chk({tag, " status before clear (R8)"}, stat_rdata, exp_stat());
    m_bfull  = wr | (m_bfull & ~ld & ~rd);
    m_perr   = (dn & pb) | (m_perr & ~rd);
    m_oerr   = (dn & ~el) | (m_oerr & ~rd);
    m_ferr   = (dn & md & (sb | pbs)) | (m_ferr & ~rd);
    m_rxfull = el | (m_rxfull & ~tk);
    m_irq    = dn;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset status", stat_rdata, 4'b0000);
    chk("R1 reset irq", {3'b0, rx_irq}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 transmit buffer flag
    cycle("R2 write",          1, 1,0,0,0,0,0,0,0);
    cycle("R3 overwrite",      1, 1,0,0,0,0,0,0,0);
    chk("R3 flag after overwrite", stat_rdata, 4'b1000);
    cycle("R2 load",           1, 0,1,0,0,0,0,0,0);
    chk("R2 cleared by load", stat_rdata, 4'b0000);
    cycle("R2 write+load",     1, 1,1,0,0,0,0,0,0);
    chk("R2 write wins over load", stat_rdata, 4'b1000);
    cycle("R2 load",           1, 0,1,0,0,0,0,0,0);

    // R6 / R5 receive gating and overrun
    cycle("R6 first rx",       1, 0,0,1,0,0,0,0,0);
    chk("R10 irq after done", {3'b0, rx_irq}, 4'b0001);
    cycle("R5 overrun rx",     1, 0,0,1,0,0,0,0,0);
    chk("R5 overrun flag", stat_rdata, 4'b0010);
    cycle("R8 read",           1, 0,0,0,0,0,0,0,1);
    chk("R8 cleared after read", stat_rdata, 4'b0000);
    cycle("R6 done+taken",     1, 0,0,1,0,0,0,1,0);
    chk("R6 no overrun with same-cycle take", stat_rdata, 4'b0000);
    cycle("R6 take",           1, 0,0,0,0,0,0,1,0);

    // R9 set beats clear, R4 parity
    cycle("R9 parity+read",    1, 0,0,1,1,0,0,1,1);
    chk("R9 parity kept over read", stat_rdata, 4'b0100);
    cycle("R4 sticky idle",    1, 0,0,0,0,0,0,1,0);
    chk("R4 parity sticky", stat_rdata, 4'b0100);
    cycle("R8 read",           1, 0,0,0,0,0,0,0,1);

    // R7 framing, mode qualified
    cycle("R7 sync stop bad",  0, 0,0,1,0,0,1,1,0);
    chk("R7 sync ignores framing", stat_rdata, 4'b0000);
    cycle("R7 back to uart",   1, 0,0,0,0,0,0,0,0);
    chk("R7 no latent framing", stat_rdata, 4'b0000);
    cycle("R7 uart start bad", 1, 0,0,1,0,1,0,1,0);
    chk("R7 framing set", stat_rdata, 4'b0001);
    chk("R10 irq on framing error", {3'b0, rx_irq}, 4'b0001);
    cycle("R10 idle",          1, 0,0,0,0,0,0,0,1);
    chk("R10 irq single cycle", {3'b0, rx_irq}, 4'b0000);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic md;
      md = ($urandom % 16) != 0 ? uart_mode : ~uart_mode;
      cycle("rand", md, ($urandom%3)==0, ($urandom%3)==0, ($urandom%3)==0,
            $urandom%2, ($urandom%4)==0, ($urandom%4)==0,
            ($urandom%4)==0, ($urandom%4)==0);
    end
    cycle("final", uart_mode, 0,0,0,0,0,0,0,0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule